// File: doc/BRIEF.md
# Software Interrupt Dispatch Unit

This block lets any of up to eight processors raise software interrupts toward its peers, or toward itself, with one 32-bit register write. The write carries the writer's processor index alongside the data. The unit decodes the word into a routing mode, a processor mask and an interrupt number. It then sets that interrupt number in the pending vector of every processor the routing selects.

Every processor owns an independent 16-bit pending vector, so one send can leave the same number pending on several processors. Each processor clears its copy on its own. A processor always sees the identifier of its lowest-numbered pending interrupt on its own port, and an acknowledge pulse retires exactly that one. The unit also reports the configured processor count, minus one, so software can size its masks.

Top module: `swi_dispatch`

## Requirements
- R1: After reset every pending vector is zero, every pending-any flag is low and every acknowledge identifier reads 1023.
- R2: A write with routing mode 0 (bits 25:24 = 0) sets, one clock later, the pending bit given by the interrupt number (bits 9:0) on every processor whose bit is set in the mask field (bits 23:16, bit 16 = processor 0).
- R3: A write with routing mode 1 sets the bit on every implemented processor except the writer (`wr_src`). The mask field is ignored.
- R4: A write with routing mode 2 sets the bit on the writer only. The mask field is ignored.
- R5: A write with routing mode 3 changes no pending bit on any processor.
- R6: A write whose interrupt number is above 15 changes no pending bit.
- R7: In routing mode 0, mask bits for processors at or above `NUM_PROC` have no effect.
- R8: `ack_id` of a processor shows its lowest-numbered pending interrupt, or 1023 when none is pending. An `ack_req` pulse clears that single bit of that processor on the next clock and leaves every other bit and processor unchanged.
- R9: When a write sets the same bit that an acknowledge clears in the same cycle, the bit remains pending.
- R10: `proc_count_m1` equals `NUM_PROC` - 1.
- R11: `pend_any` of a processor is high exactly when its pending vector is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the send register |
| wr_data | input | 32 | Send word: number in 9:0, mask in 23:16, mode in 25:24 |
| wr_src | input | 3 | Index of the processor issuing the write |
| ack_req | input | NUM_PROC | Per-processor acknowledge pulse |
| ack_id | output | NUM_PROC*10 | Per-processor lowest pending identifier, 1023 when none |
| pend | output | NUM_PROC*16 | Per-processor pending vectors, processor p at bits p*16 upward |
| pend_any | output | NUM_PROC | Per-processor nonzero-pending flag |
| proc_count_m1 | output | 3 | Implemented processor count minus one |

## Verification
Sends are tried in each routing mode from several writer indices and with masks that do and do not carry bits above the implemented count. Together these separate correct mode decoding from mask-only routing and from self-exclusion errors. Reserved-mode and out-of-range numbers are each sent with a mask that would otherwise hit, so an ignored write can be told apart from a misrouted one. Acknowledges drain vectors that hold several numbers, which shows lowest-first order and single-bit clearing. A write that lands on the bit being acknowledged, and one that lands beside it, show which of the two operations takes effect.

// File: rtl/swi_pkg.sv
package swi_pkg;

   localparam int SWI_CNT  = 16;
   localparam int SWI_IDXW = 4;
   localparam int ID_W     = 10;
   localparam int SRC_W    = 3;
   localparam int MAX_PROC = 8;

   localparam int NUM_LSB  = 0;
   localparam int MASK_LSB = 16;
   localparam int MODE_LSB = 24;

   localparam logic [ID_W-1:0] IDLE_ID = 10'd1023;

   typedef enum logic [1:0] {
      ROUTE_LIST   = 2'd0,
      ROUTE_OTHERS = 2'd1,
      ROUTE_SELF   = 2'd2,
      ROUTE_RSVD   = 2'd3
   } route_e;

   typedef struct packed {
      route_e                route;
      logic [MAX_PROC-1:0]   mask;
      logic [ID_W-1:0]       num;
   } send_word_t;

   function automatic send_word_t unpack_send(input logic [31:0] w);
      send_word_t s;
      s.route = route_e'(w[MODE_LSB +: 2]);
      s.mask  = w[MASK_LSB +: MAX_PROC];
      s.num   = w[NUM_LSB +: ID_W];
      return s;
   endfunction

endpackage

// File: rtl/swi_decode.sv
module swi_decode
   import swi_pkg::*;
#(
   parameter int NUM_PROC = 4
) (
   input  logic                 wr_en,
   input  logic [31:0]          wr_data,
   input  logic [SRC_W-1:0]     wr_src,
   output logic [NUM_PROC-1:0]  set_mask,
   output logic [SWI_CNT-1:0]   set_vec
);

   send_word_t            word;
   logic                  num_ok;
   logic [NUM_PROC-1:0]   self_sel;
   logic [NUM_PROC-1:0]   route_sel;
   logic                  unused_bits;

   assign word        = unpack_send(wr_data);
   assign num_ok      = (word.num < ID_W'(SWI_CNT));
   assign unused_bits = ^{wr_data[31:26], wr_data[15:10]};

   for (genvar p = 0; p < NUM_PROC; p++) begin : g_self
      assign self_sel[p] = (wr_src == SRC_W'(p));
   end

   always_comb begin
      route_sel = '0;
      case (word.route)
         ROUTE_LIST:   route_sel = word.mask[NUM_PROC-1:0];
         ROUTE_OTHERS: route_sel = ~self_sel;
         ROUTE_SELF:   route_sel = self_sel;
         default:      route_sel = '0;
      endcase
   end

   assign set_mask = (wr_en && num_ok) ? route_sel : '0;

   always_comb begin
      set_vec = '0;
      set_vec[word.num[SWI_IDXW-1:0]] = 1'b1;
   end

endmodule

// File: rtl/swi_pick.sv
module swi_pick #(
   parameter int W = 16,
   localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]     vec,
   output logic             found,
   output logic [IDX_W-1:0] idx
);

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/swi_pend_bank.sv
module swi_pend_bank
   import swi_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_en,
   input  logic [SWI_CNT-1:0] set_vec,
   input  logic               ack_req,
   output logic [SWI_CNT-1:0] pend,
   output logic               pend_any,
   output logic [ID_W-1:0]    ack_id
);

   logic [SWI_CNT-1:0]  pend_q;
   logic [SWI_CNT-1:0]  clr_vec;
   logic [SWI_CNT-1:0]  add_vec;
   logic                found;
   logic [SWI_IDXW-1:0] low_idx;

   swi_pick #(.W(SWI_CNT)) i_pick (
      .vec   (pend_q),
      .found (found),
      .idx   (low_idx)
   );

   always_comb begin
      clr_vec = '0;
      if (ack_req && found) clr_vec[low_idx] = 1'b1;
   end

   assign add_vec = set_en ? set_vec : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr_vec) | add_vec;
   end

   assign pend     = pend_q;
   assign pend_any = found;
   assign ack_id   = found ? ID_W'(low_idx) : IDLE_ID;

endmodule

// File: rtl/swi_dispatch.sv
module swi_dispatch
   import swi_pkg::*;
#(
   parameter int NUM_PROC = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [31:0]                 wr_data,
   input  logic [2:0]                  wr_src,
   input  logic [NUM_PROC-1:0]         ack_req,
   output logic [NUM_PROC*10-1:0]      ack_id,
   output logic [NUM_PROC*16-1:0]      pend,
   output logic                        [NUM_PROC-1:0] pend_any,
   output logic [2:0]                  proc_count_m1
);

   if (NUM_PROC < 1 || NUM_PROC > MAX_PROC) begin : g_bad_count
      $error("swi_dispatch: NUM_PROC must lie in 1..8");
   end
   if (ID_W != 10 || SWI_CNT != 16) begin : g_bad_widths
      $error("swi_dispatch: port widths assume 10-bit ids and 16 numbers");
   end

   logic [NUM_PROC-1:0] set_mask;
   logic [SWI_CNT-1:0]  set_vec;

   swi_decode #(.NUM_PROC(NUM_PROC)) i_decode (
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .wr_src   (wr_src),
      .set_mask (set_mask),
      .set_vec  (set_vec)
   );

   for (genvar p = 0; p < NUM_PROC; p++) begin : g_proc
      swi_pend_bank i_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .set_en   (set_mask[p]),
         .set_vec  (set_vec),
         .ack_req  (ack_req[p]),
         .pend     (pend[p*SWI_CNT +: SWI_CNT]),
         .pend_any (pend_any[p]),
         .ack_id   (ack_id[p*ID_W +: ID_W])
      );
   end

   assign proc_count_m1 = 3'(NUM_PROC - 1);

endmodule

// File: rtl/swi_dispatch_chk.sv
module swi_dispatch_chk #(
   parameter int NUM_PROC = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [31:0]            wr_data,
   input  logic [2:0]             wr_src,
   input  logic [NUM_PROC-1:0]    ack_req,
   input  logic [NUM_PROC*10-1:0] ack_id,
   input  logic [NUM_PROC*16-1:0] pend,
   input  logic [NUM_PROC-1:0]    pend_any,
   input  logic [2:0]             proc_count_m1
);

   logic [1:0] c_mode;
   logic [9:0] c_num;
   logic       c_ok;
   assign c_mode = wr_data[25:24];
   assign c_num  = wr_data[9:0];
   assign c_ok   = (c_num < 10'd16);

   assert_count_R10: assert property (@(posedge clk)
      proc_count_m1 == 3'(NUM_PROC - 1));

   assert_reserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && c_mode == 2'd3 && ack_req == '0) |=> $stable(pend));

   assert_bad_num_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !c_ok && ack_req == '0) |=> $stable(pend));

   for (genvar p = 0; p < NUM_PROC; p++) begin : g_p
      assert_list_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && c_mode == 2'd0 && c_ok && wr_data[16+p])
         |=> pend[p*16 + $past(c_num[3:0])]);

      assert_others_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && c_mode == 2'd1 && wr_src == 3'(p) && !ack_req[p])
         |=> $stable(pend[p*16 +: 16]));

      assert_self_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && c_mode == 2'd2 && wr_src != 3'(p) && !ack_req[p])
         |=> $stable(pend[p*16 +: 16]));

      assert_idle_id_R8: assert property (@(posedge clk) disable iff (!rst_n)
         !pend_any[p] |-> ack_id[p*10 +: 10] == 10'd1023);

      assert_ack_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_req[p] && pend_any[p] && !wr_en)
         |=> !pend[p*16 + $past(ack_id[p*10 +: 4])]);

      assert_any_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
         pend_any[p] == (pend[p*16 +: 16] != 16'd0));
   end

endmodule

bind swi_dispatch swi_dispatch_chk #(.NUM_PROC(NUM_PROC)) i_chk (.*);

// File: tb/test_swi_dispatch.sv
`timescale 1ns/1ps
module test_swi_dispatch;

   localparam int NP = 4;

   logic           clk = 1'b0;
   logic           rst_n;
   logic           wr_en;
   logic [31:0]    wr_data;
   logic [2:0]     wr_src;
   logic [NP-1:0]  ack_req;
   logic [NP*10-1:0] ack_id;
   logic [NP*16-1:0] pend;
   logic [NP-1:0]  pend_any;
   logic [2:0]     proc_count_m1;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   logic [15:0] model [NP];

   always #5 clk = ~clk;

   swi_dispatch #(.NUM_PROC(NP)) i_swi_dispatch (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .wr_src(wr_src), .ack_req(ack_req), .ack_id(ack_id), .pend(pend),
      .pend_any(pend_any), .proc_count_m1(proc_count_m1)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] word(input int mode, input int mask, input int num);
      return (32'(mode) << 24) | (32'(mask) << 16) | 32'(num);
   endfunction

   function automatic logic [9:0] low_id(input logic [15:0] v);
      for (int i = 0; i < 16; i++) if (v[i]) return 10'(i);
      return 10'd1023;
   endfunction

   // Model of the routing rules (R2..R7)
   task automatic model_write(input int mode, input int mask, input int num, input int src);
      if (num > 15 || mode == 3) return;
      for (int p = 0; p < NP; p++) begin
         bit hit;
         hit = (mode == 0) ? mask[p] : (mode == 1) ? (p != src) : (p == src);
         if (hit) model[p][num] = 1'b1;
      end
   endtask

   task automatic send(input int mode, input int mask, input int num, input int src);
      @(negedge clk);
      wr_en = 1'b1; wr_data = word(mode, mask, num); wr_src = 3'(src);
      @(negedge clk);
      wr_en = 1'b0;
      model_write(mode, mask, num, src);
   endtask

   task automatic compare_all(input string tag);
      for (int p = 0; p < NP; p++) begin
         check(tag, 32'(pend[p*16 +: 16]), 32'(model[p]));
         check("R11", 32'(pend_any[p]), 32'(model[p] != 0));
         check("R8", 32'(ack_id[p*10 +: 10]), 32'(low_id(model[p])));
      end
   endtask

   task automatic drain();
      @(negedge clk);
      ack_req = '1;
      repeat (17) @(negedge clk);
      ack_req = '0;
      for (int p = 0; p < NP; p++) model[p] = '0;
   endtask

   task automatic t_reset();
      for (int p = 0; p < NP; p++) model[p] = '0;
      compare_all("R1");
      check("R10", 32'(proc_count_m1), 32'(NP - 1));
   endtask

   task automatic t_list();
      send(0, 8'h05, 7, 0);
      compare_all("R2");
      send(0, 8'hF2, 3, 2);   // bits 7:4 above NP must do nothing (R7)
      compare_all("R7");
      send(0, 8'h00, 9, 1);
      compare_all("R2");
      drain();
   endtask

   task automatic t_others();
      send(1, 8'h00, 4, 1);
      compare_all("R3");
      send(1, 8'h08, 12, 3);  // mask ignored
      compare_all("R3");
      drain();
   endtask

   task automatic t_self();
      send(2, 8'h0F, 6, 2);
      compare_all("R4");
      send(2, 8'h00, 0, 0);
      compare_all("R4");
      drain();
   endtask

   task automatic t_ignored();
      send(3, 8'h0F, 5, 0);
      compare_all("R5");
      send(0, 8'h0F, 16, 0);
      compare_all("R6");
      send(1, 8'h00, 1023, 2);
      compare_all("R6");
   endtask

   task automatic t_ack();
      send(0, 8'h03, 9, 0);
      send(0, 8'h01, 2, 0);
      send(0, 8'h01, 14, 0);
      compare_all("R8");
      for (int k = 0; k < 4; k++) begin
         logic [9:0] exp_id;
         exp_id = low_id(model[0]);
         check("R8", 32'(ack_id[9:0]), 32'(exp_id));
         @(negedge clk); ack_req = 4'b0001;
         @(negedge clk); ack_req = '0;
         if (exp_id != 10'd1023) model[0][exp_id[3:0]] = 1'b0;
         compare_all("R8");
      end
      drain();
   endtask

   task automatic t_collide();
      send(0, 8'h02, 3, 0);
      send(0, 8'h02, 5, 0);
      // ack retires 3 while a write re-raises 3: stays pending
      @(negedge clk);
      ack_req = 4'b0010; wr_en = 1'b1; wr_data = word(0, 8'h02, 3); wr_src = 3'd0;
      @(negedge clk);
      ack_req = '0; wr_en = 1'b0;
      compare_all("R9");
      // ack retires 3 while write sets 8: 3 cleared, 8 set
      @(negedge clk);
      ack_req = 4'b0010; wr_en = 1'b1; wr_data = word(0, 8'h02, 8); wr_src = 3'd0;
      @(negedge clk);
      ack_req = '0; wr_en = 1'b0;
      model[1][3] = 1'b0; model[1][8] = 1'b1;
      compare_all("R9");
      drain();
      compare_all("R8");
   endtask

   task automatic finish_run();
      if (done) return;
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; wr_src = '0; ack_req = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_list();
      t_others();
      t_self();
      t_ignored();
      t_ack();
      t_collide();
      finish_run();
   end

endmodule